// File: doc/BRIEF.md
# Overlap-Safe Block Move Engine

This engine copies a run of bytes from one place in a 24-bit address space to another, one byte at a time, through a single byte-wide memory port. A one-cycle start pulse captures the job parameters:
- a 16-bit length, given as the number of bytes minus one;
- a 16-bit source offset and a 16-bit destination offset;
- a two-byte bank field that holds the destination bank and the source bank.

Every byte takes one read cycle followed by one write cycle. The engine then steps the offsets and counts the length down until it wraps to all ones.

A direction input selects how the offsets move. In ascending mode they point at the lowest bytes of both ranges and count up. In descending mode they point at the highest bytes and count down. Overlapping ranges can therefore be copied without clobbering source bytes that have not yet been read: use ascending mode when the destination lies below the source, and descending mode when it lies above. A narrow-index input restricts both offsets to the first 256 bytes of their banks. When the job finishes, the final count and offsets stay visible on the outputs.

Top module: `blkmv_engine`

## Requirements
- R1: A length value L moves exactly L+1 bytes, so L = 0 moves one byte. When the move finishes, `cnt_out` reads 0xFFFF.
- R2: With `dir_desc` = 0, byte k (counting from 0) is read at source offset + k and written at destination offset + k.
- R3: With `dir_desc` = 1, byte k is read at source offset - k and written at destination offset - k.
- R4: Each byte uses one cycle with `mem_rd` = 1, in which `mem_rdata` is sampled. The very next cycle has `mem_wr` = 1, and `mem_wdata` equals the byte just read. There are no idle cycles between bytes, so an N-byte move keeps `busy` high for 2N cycles.
- R5: `mem_addr` is {bank, offset}: bits 23:16 hold the bank and bits 15:0 hold the offset. Reads use the source bank and writes use the destination bank.
- R6: In `banks_in`, bits 7:0 carry the destination bank and bits 15:8 carry the source bank.
- R7: With `idx_narrow` = 1 at start, both offsets are captured with bits 15:8 cleared. They then step within their low 8 bits (0xFF wraps to 0x00 and back), and bits 15:8 stay zero.
- R8: With `idx_narrow` = 0, offsets wrap between 0xFFFF and 0x0000 without changing the bank byte of the address.
- R9: A start pulse while `busy` is high is ignored. Parameters are captured only in the cycle where start is accepted.
- R10: `done` is high for exactly one cycle, the cycle after the final write, and `busy` falls in that same cycle. `cnt_out`, `src_off_out` and `dst_off_out` then hold their final values until the next start.
- R11: After reset: `busy`, `done`, `mem_rd` and `mem_wr` are 0, `cnt_out` is 0xFFFF, and both offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only while idle |
| dir_desc | input | 1 | 0 = ascending, 1 = descending |
| idx_narrow | input | 1 | 1 = offsets limited to 8 bits |
| cnt_in | input | 16 | Byte count minus one |
| src_off_in | input | 16 | Source offset |
| dst_off_in | input | 16 | Destination offset |
| banks_in | input | 16 | [7:0] destination bank, [15:8] source bank |
| mem_addr | output | 24 | Memory address {bank, offset} |
| mem_rd | output | 1 | Read cycle strobe |
| mem_wr | output | 1 | Write cycle strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the read cycle |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_out | output | 16 | Current count |
| src_off_out | output | 16 | Current source offset |
| dst_off_out | output | 16 | Current destination offset |

## Verification
The bench sweeps short lengths in both directions, in both index widths, and with overlapping ranges. Each run is compared against a byte-by-byte reference copy, so an engine that stepped the wrong way would destroy source bytes and leave a corrupted destination. Offsets placed next to 0xFFFF, 0x0000 and the page-0 boundary expose a carry that leaks into the bank byte, or a narrow offset that escapes into its high byte; the bench checks each address exactly. The bench also checks the length-of-zero case and the cycle on which `done` appears. Any off-by-one in the count-minus-one rule shows up as one byte too many or too few, or as a shifted `done`. A start pulse injected in the middle of a move catches an engine that reloads its parameters.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
  localparam int BMV_CNT_W    = 16;
  localparam int BMV_OFF_W    = 16;
  localparam int BMV_BANK_W   = 8;
  localparam int BMV_DATA_W   = 8;
  localparam int BMV_NARROW_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } bmv_state_e;
endpackage

// File: rtl/blkmv_seq.sv
module blkmv_seq
  import blkmv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       last_byte,
  output bmv_state_e state,
  output logic       load,
  output logic       step,
  output logic       busy,
  output logic       done
);
  bmv_state_e state_d;
  logic       finish_evt;

  assign load       = start && (state == ST_IDLE);
  assign step       = (state == ST_WRITE);
  assign finish_evt = step && last_byte;
  assign busy       = (state != ST_IDLE);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = last_byte ? ST_IDLE : ST_READ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= finish_evt;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ) |=> (state == ST_WRITE)); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

// File: rtl/blkmv_regs.sv
module blkmv_regs #(
  parameter int CNT_W    = 16,
  parameter int OFF_W    = 16,
  parameter int BANK_W   = 8,
  parameter int NARROW_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic                dir_desc,
  input  logic                idx_narrow,
  input  logic [CNT_W-1:0]    cnt_in,
  input  logic [OFF_W-1:0]    src_in,
  input  logic [OFF_W-1:0]    dst_in,
  input  logic [2*BANK_W-1:0] banks_in,
  output logic [CNT_W-1:0]    cnt_q,
  output logic [OFF_W-1:0]    src_q,
  output logic [OFF_W-1:0]    dst_q,
  output logic [BANK_W-1:0]   src_bank,
  output logic [BANK_W-1:0]   dst_bank,
  output logic                last_byte
);
  localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic desc_q;
  logic narrow_q;

  function automatic logic [OFF_W-1:0] clip_off(input logic [OFF_W-1:0] off,
                                                input logic narrow);
    logic [OFF_W-1:0] r;
    r = off;
    if (narrow) r[OFF_W-1:NARROW_W] = '0;
    return r;
  endfunction

  function automatic logic [OFF_W-1:0] step_off(input logic [OFF_W-1:0] off,
                                                input logic desc,
                                                input logic narrow);
    logic [OFF_W-1:0] r;
    r = desc ? (off - OFF_ONE) : (off + OFF_ONE);
    return clip_off(r, narrow);
  endfunction

  assign last_byte = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      src_q    <= '0;
      dst_q    <= '0;
      src_bank <= '0;
      dst_bank <= '0;
      desc_q   <= 1'b0;
      narrow_q <= 1'b0;
    end else if (load) begin
      cnt_q    <= cnt_in;
      src_q    <= clip_off(src_in, idx_narrow);
      dst_q    <= clip_off(dst_in, idx_narrow);
      dst_bank <= banks_in[BANK_W-1:0];
      src_bank <= banks_in[2*BANK_W-1:BANK_W];
      desc_q   <= dir_desc;
      narrow_q <= idx_narrow;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_ONE;
      src_q <= step_off(src_q, desc_q, narrow_q);
      dst_q <= step_off(dst_q, desc_q, narrow_q);
    end
  end

  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_q && !load) |=> (src_q[OFF_W-1:NARROW_W] == '0) && (dst_q[OFF_W-1:NARROW_W] == '0)); // R7
  AST_FINAL_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_byte) |=> (cnt_q == '1)); // R1
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(src_bank) && $stable(dst_bank)); // R9
endmodule

// File: rtl/blkmv_engine.sv
module blkmv_engine
  import blkmv_pkg::*;
#(
  parameter int CNT_W    = BMV_CNT_W,
  parameter int OFF_W    = BMV_OFF_W,
  parameter int BANK_W   = BMV_BANK_W,
  parameter int DATA_W   = BMV_DATA_W,
  parameter int NARROW_W = BMV_NARROW_W,
  localparam int ADDR_W  = BANK_W + OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                dir_desc,
  input  logic                idx_narrow,
  input  logic [CNT_W-1:0]    cnt_in,
  input  logic [OFF_W-1:0]    src_off_in,
  input  logic [OFF_W-1:0]    dst_off_in,
  input  logic [2*BANK_W-1:0] banks_in,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [CNT_W-1:0]    cnt_out,
  output logic [OFF_W-1:0]    src_off_out,
  output logic [OFF_W-1:0]    dst_off_out
);
  bmv_state_e          state;
  logic                load;
  logic                step;
  logic                last_byte;
  logic [BANK_W-1:0]   src_bank;
  logic [BANK_W-1:0]   dst_bank;
  logic [DATA_W-1:0]   byte_q;

  blkmv_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .last_byte (last_byte),
    .state     (state),
    .load      (load),
    .step      (step),
    .busy      (busy),
    .done      (done)
  );

  blkmv_regs #(
    .CNT_W    (CNT_W),
    .OFF_W    (OFF_W),
    .BANK_W   (BANK_W),
    .NARROW_W (NARROW_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .dir_desc   (dir_desc),
    .idx_narrow (idx_narrow),
    .cnt_in     (cnt_in),
    .src_in     (src_off_in),
    .dst_in     (dst_off_in),
    .banks_in   (banks_in),
    .cnt_q      (cnt_out),
    .src_q      (src_off_out),
    .dst_q      (dst_off_out),
    .src_bank   (src_bank),
    .dst_bank   (dst_bank),
    .last_byte  (last_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 byte_q <= '0;
    else if (state == ST_READ)  byte_q <= mem_rdata;
  end

  assign mem_rd    = (state == ST_READ);
  assign mem_wr    = (state == ST_WRITE);
  assign mem_wdata = byte_q;
  assign mem_addr  = mem_wr ? {dst_bank, dst_off_out} : {src_bank, src_off_out};

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R4
  AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == $past(mem_rdata))); // R4
  AST_ADDR_BANK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_wr)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W], 2))); // R8
endmodule

// File: tb/blkmv_engine_test.sv
module blkmv_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_desc = 1'b0;
  logic        idx_narrow = 1'b0;
  logic [15:0] cnt_in = '0;
  logic [15:0] src_off_in = '0;
  logic [15:0] dst_off_in = '0;
  logic [15:0] banks_in = '0;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done;
  logic [15:0] cnt_out, src_off_out, dst_off_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem_model [0:4095];
  logic [7:0] shadow    [0:4095];

  logic [15:0] mon_src, mon_dst;
  logic [7:0]  mon_sb, mon_db, mon_byte;
  logic        mon_desc, mon_nar;
  int          mon_bytes;

  always #5 clk = ~clk;

  blkmv_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_desc(dir_desc),
    .idx_narrow(idx_narrow), .cnt_in(cnt_in), .src_off_in(src_off_in),
    .dst_off_in(dst_off_in), .banks_in(banks_in), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .cnt_out(cnt_out),
    .src_off_out(src_off_out), .dst_off_out(dst_off_out)
  );

  function automatic logic [11:0] fold(input logic [23:0] a);
    return {a[17:16], a[9:0]};
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] off, input logic desc, input logic nar);
    if (nar) return {8'h00, desc ? off[7:0] - 8'd1 : off[7:0] + 8'd1};
    return desc ? off - 16'd1 : off + 16'd1;
  endfunction

  assign mem_rdata = mem_model[fold(mem_addr)];

  always @(posedge clk) if (mem_wr) mem_model[fold(mem_addr)] = mem_wdata;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_rd) begin
      check(mem_addr == {mon_sb, mon_src}, "R5", "read address (R2 up / R3 down)",
            {8'h0, mem_addr}, {8'h0, mon_sb, mon_src});
      mon_byte = shadow[fold({mon_sb, mon_src})];
    end
    if (rst_n && mem_wr) begin
      check(mem_addr == {mon_db, mon_dst}, "R6", "write address and bank order",
            {8'h0, mem_addr}, {8'h0, mon_db, mon_dst});
      check(mem_wdata == mon_byte, "R4", "write data", {24'h0, mem_wdata}, {24'h0, mon_byte});
      shadow[fold({mon_db, mon_dst})] = mon_byte;
      mon_src = nxt(mon_src, mon_desc, mon_nar);
      mon_dst = nxt(mon_dst, mon_desc, mon_nar);
      mon_bytes++;
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < 4096; i++) begin
      mem_model[i] = 8'((i * 7 + seed * 13 + (i >> 8)) & 255);
      shadow[i]    = mem_model[i];
    end
  endtask

  task automatic run(input logic [15:0] cnt, input logic [15:0] s, input logic [15:0] d,
                     input logic [7:0] sb, input logic [7:0] db, input logic desc,
                     input logic nar, input bit disturb);
    int k;
    int n;
    int bad;
    logic [15:0] es, ed;
    n = int'(cnt) + 1;
    mon_sb = sb; mon_db = db; mon_desc = desc; mon_nar = nar; mon_bytes = 0;
    mon_src = nar ? {8'h00, s[7:0]} : s;
    mon_dst = nar ? {8'h00, d[7:0]} : d;
    if (nar) begin
      es = {8'h00, desc ? s[7:0] - n[7:0] : s[7:0] + n[7:0]};
      ed = {8'h00, desc ? d[7:0] - n[7:0] : d[7:0] + n[7:0]};
    end else begin
      es = desc ? s - n[15:0] : s + n[15:0];
      ed = desc ? d - n[15:0] : d + n[15:0];
    end
    @(negedge clk);
    cnt_in = cnt; src_off_in = s; dst_off_in = d; banks_in = {sb, db};
    dir_desc = desc; idx_narrow = nar; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 140000) begin
      if (disturb && k == 3) begin
        start = 1'b1; cnt_in = 16'h0000; src_off_in = 16'h0333;
        dst_off_in = 16'h0055; banks_in = 16'h0303; dir_desc = ~desc; idx_narrow = ~nar;
      end else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(k == 2 * n + 1, disturb ? "R9" : "R10", "cycle of done", k, 2 * n + 1);
    check(!busy, "R10", "busy low with done", {31'h0, busy}, 0);
    check(cnt_out == 16'hFFFF, "R1", "final count", {16'h0, cnt_out}, 32'hFFFF);
    check(mon_bytes == n, "R1", "bytes moved", mon_bytes, n);
    check(src_off_out == es, nar ? "R7" : "R8", "final source offset", {16'h0, src_off_out}, {16'h0, es});
    check(dst_off_out == ed, desc ? "R3" : "R2", "final destination offset", {16'h0, dst_off_out}, {16'h0, ed});
    @(negedge clk);
    check(!done, "R10", "done pulse width", {31'h0, done}, 0);
    check(cnt_out == 16'hFFFF && src_off_out == es && dst_off_out == ed, "R10",
          "outputs held after done", {cnt_out, src_off_out}, {16'hFFFF, es});
    bad = 0;
    for (int i = 0; i < 4096; i++) if (mem_model[i] !== shadow[i]) bad++;
    check(bad == 0, "R4", "memory image vs reference copy", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mon_src = '0; mon_dst = '0; mon_sb = '0; mon_db = '0; mon_byte = '0;
    mon_desc = 1'b0; mon_nar = 1'b0; mon_bytes = 0;
    fill(0);
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_rd && !mem_wr, "R11", "reset strobes",
          {28'h0, busy, done, mem_rd, mem_wr}, 0);
    check(cnt_out == 16'hFFFF && src_off_out == 0 && dst_off_out == 0, "R11",
          "reset registers", {cnt_out, src_off_out}, {16'hFFFF, 16'h0});
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_rd, "R11", "idle after reset release", {30'h0, busy, mem_rd}, 0);

    // R1: zero length moves a single byte
    fill(1); run(16'h0000, 16'h0010, 16'h0020, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    fill(2); run(16'h0000, 16'h0010, 16'h0020, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    // R2 / R3: overlapping ranges in the safe direction
    fill(3); run(16'h000F, 16'h0108, 16'h0104, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0);
    fill(4); run(16'h000F, 16'h0117, 16'h011B, 8'h01, 8'h01, 1'b1, 1'b0, 1'b0);
    // R6: distinct banks
    fill(5); run(16'h0007, 16'h0200, 16'h0200, 8'h01, 8'h02, 1'b0, 1'b0, 1'b0);
    // R8: 16-bit wrap in both directions
    fill(6); run(16'h0003, 16'h0080, 16'hFFFE, 8'h02, 8'h03, 1'b0, 1'b0, 1'b0);
    fill(7); run(16'h0003, 16'h0001, 16'h0090, 8'h03, 8'h01, 1'b1, 1'b0, 1'b0);
    // R7: narrow index masks and wraps inside page zero
    fill(8); run(16'h0005, 16'h12FC, 16'hAB40, 8'h00, 8'h02, 1'b0, 1'b1, 1'b0);
    fill(9); run(16'h0005, 16'h3402, 16'h5660, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0);
    fill(10); run(16'h00FF, 16'h0000, 16'h0180, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0);
    // R9: start during a move is ignored
    fill(11); run(16'h0009, 16'h0300, 16'h0340, 8'h00, 8'h01, 1'b0, 1'b0, 1'b1);

    // sweep: lengths, directions, widths, offset pairs
    for (int len = 0; len < 8; len++)
      for (int dr = 0; dr < 2; dr++)
        for (int nr = 0; nr < 2; nr++)
          for (int p = 0; p < 3; p++) begin
            logic [15:0] s, d;
            case (p)
              0: begin s = 16'h01F8; d = 16'h01FB; end
              1: begin s = 16'h02FD; d = 16'h02FA; end
              default: begin s = 16'hFFFC; d = 16'h0003; end
            endcase
            fill(len * 12 + dr * 6 + nr * 3 + p);
            run(16'(len), s, d, 8'(p), 8'(p + 1), dr[0], nr[0], 1'b0);
          end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule